// File: doc/BRIEF.md
# Phase-Continuous FSK Tone Generator

This block is the digital core of a half-duplex 1200 bit/s FSK transmitter with the two tone frequencies used on 4-20 mA loop signalling. It runs one update per system clock, nominally 460.8 kHz. A serial NRZ data bit chooses the tone: a 1 (mark) selects 1200 Hz and a 0 (space) selects 2200 Hz, so each 833 µs bit spans 384 clocks. A 24-bit phase accumulator advances by a tone-dependent increment each clock and is never reloaded on a tone change, so the waveform stays continuous in phase. All tone frequencies scale with the clock rate.

The top bit of the phase selects a high or a low plateau, and a slew limiter walks a multi-bit sample toward that plateau by a fixed step each clock. The result is a trapezoid whose edges are steeper for the space tone than for the mark tone. An active-low transmit request gates the oscillator. While it is high the phase is held at zero and the sample glides back to mid-scale, the idle level that an external DAC expects. The samples go to that DAC, and the analog stage after it is outside this block.

Top module: `fsk_tone_gen`

## Requirements
- R1: A synchronous reset, sampled high at a clock edge, sets `phase_o` to 0 and `sample_o` to mid-scale (512 with the default 10-bit sample) at that edge.
- R2: While `rts_n` is 0 and `tx_bit` is 1, each clock edge adds the mark increment (default 43691, about 1200 Hz at 460.8 kHz) to `phase_o`, modulo 2^24.
- R3: While `rts_n` is 0 and `tx_bit` is 0, each clock edge adds the space increment (default 80100, about 2200 Hz at 460.8 kHz) to `phase_o`, modulo 2^24.
- R4: A change of `tx_bit` does not reload the phase. The first increment of the new tone is added to the phase value left by the old tone.
- R5: While `rts_n` is 1, `phase_o` becomes 0 at the next clock edge and stays 0.
- R6: While `rts_n` is 0, the sample target is the high level (768) when bit 23 of `phase_o` is 1 and the low level (256) when that bit is 0. While `rts_n` is 1, the target is mid-scale (512). Once reached, a target is held.
- R7: At each edge `sample_o` moves toward the target chosen from the pre-edge `phase_o`, `rts_n` and `tx_bit`. It moves by the tone's step (default 4 for mark, 7 for space) and lands exactly on the target when the remaining distance is no more than one step.
- R8: While `rts_n` is 1, `sample_o` returns to mid-scale by the mark step per clock and then stays there.
- R9: `sample_o` never leaves the range from the low level to the high level, inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rts_n | input | 1 | Active-low transmit request; high means idle |
| tx_bit | input | 1 | NRZ data bit: 1 = mark tone, 0 = space tone |
| phase_o | output | 24 | Phase accumulator value |
| sample_o | output | 10 | Slew-limited trapezoid sample for the DAC |

## Verification
The bench builds the block with its default parameters: a 24-bit accumulator, a 10-bit sample with plateaus at 256 and 768, and steps of 4 and 7. With these values a mark cycle takes about 384 clocks and a space cycle about 209. Several accumulator wraps, full plateau-to-plateau ramps at both slopes, and tone changes part-way through a ramp therefore all fit in a few thousand cycles. A reference model checks every cycle of continuous tones, rapid and bit-rate tone changes, idle ramp-down and a mid-run reset.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

    typedef struct packed {
        logic  run;
        tone_e tone;
    } tx_ctl_t;

    function automatic tx_ctl_t decode_ctl(input logic rts_n, input logic bit_in);
        tx_ctl_t c;
        c.run  = ~rts_n;
        c.tone = bit_in ? TONE_MARK : TONE_SPACE;
        return c;
    endfunction

endpackage

// File: rtl/fsk_tone_select.sv
module fsk_tone_select
    import fsk_pkg::*;
#(
    parameter int ACC_W      = 24,
    parameter int SMP_W      = 10,
    parameter int INC_MARK   = 43691,
    parameter int INC_SPACE  = 80100,
    parameter int STEP_MARK  = 4,
    parameter int STEP_SPACE = 7
) (
    input  tx_ctl_t          ctl,
    output logic [ACC_W-1:0] inc,
    output logic [SMP_W-1:0] step
);
    localparam logic [ACC_W-1:0] INC_M_V  = ACC_W'(INC_MARK);
    localparam logic [ACC_W-1:0] INC_S_V  = ACC_W'(INC_SPACE);
    localparam logic [SMP_W-1:0] STEP_M_V = SMP_W'(STEP_MARK);
    localparam logic [SMP_W-1:0] STEP_S_V = SMP_W'(STEP_SPACE);

    always_comb begin
        inc  = (ctl.tone == TONE_MARK) ? INC_M_V : INC_S_V;
        // idle ramp uses the gentler mark slope
        step = (ctl.run && ctl.tone == TONE_SPACE) ? STEP_S_V : STEP_M_V;
    end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + inc;
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0)); // R5

    AST_PHASE_CONT: assert property (@(posedge clk) disable iff (rst)
        run |=> (phase == ACC_W'($past(phase) + $past(inc)))); // R4
endmodule

// File: rtl/fsk_slew_shaper.sv
module fsk_slew_shaper #(
    parameter int SMP_W     = 10,
    parameter int LEVEL_LO  = 256,
    parameter int LEVEL_MID = 512,
    parameter int LEVEL_HI  = 768,
    parameter int STEP_MAX  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             phase_msb,
    input  logic [SMP_W-1:0] step,
    output logic [SMP_W-1:0] sample
);
    localparam logic [SMP_W-1:0] LO_V  = SMP_W'(LEVEL_LO);
    localparam logic [SMP_W-1:0] MID_V = SMP_W'(LEVEL_MID);
    localparam logic [SMP_W-1:0] HI_V  = SMP_W'(LEVEL_HI);
    localparam logic [SMP_W-1:0] SMAX_V = SMP_W'(STEP_MAX);

    logic [SMP_W-1:0] target;
    logic [SMP_W-1:0] sample_d;

    always_comb begin
        target = run ? (phase_msb ? HI_V : LO_V) : MID_V;
        if (sample < target)
            sample_d = ((target - sample) <= step) ? target : sample + step;
        else if (sample > target)
            sample_d = ((sample - target) <= step) ? target : sample - step;
        else
            sample_d = sample;
    end

    always_ff @(posedge clk) begin
        if (rst) sample <= MID_V;
        else     sample <= sample_d;
    end

    AST_SLEW_BOUND: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((sample > $past(sample)) ? (sample - $past(sample))
                                              : ($past(sample) - sample)) <= SMAX_V)); // R7

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (sample >= LO_V) && (sample <= HI_V)); // R9

    AST_IDLE_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (!run && sample == MID_V) |=> (sample == MID_V)); // R8
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
    import fsk_pkg::*;
#(
    parameter int ACC_W      = 24,
    parameter int SMP_W      = 10,
    parameter int INC_MARK   = 43691,
    parameter int INC_SPACE  = 80100,
    parameter int STEP_MARK  = 4,
    parameter int STEP_SPACE = 7,
    parameter int LEVEL_LO   = 256,
    parameter int LEVEL_MID  = 512,
    parameter int LEVEL_HI   = 768
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rts_n,
    input  logic             tx_bit,
    output logic [ACC_W-1:0] phase_o,
    output logic [SMP_W-1:0] sample_o
);
    localparam int STEP_MAX = (STEP_SPACE > STEP_MARK) ? STEP_SPACE : STEP_MARK;

    tx_ctl_t          ctl;
    logic [ACC_W-1:0] inc;
    logic [SMP_W-1:0] step;

    assign ctl = decode_ctl(rts_n, tx_bit);

    fsk_tone_select #(
        .ACC_W(ACC_W), .SMP_W(SMP_W),
        .INC_MARK(INC_MARK), .INC_SPACE(INC_SPACE),
        .STEP_MARK(STEP_MARK), .STEP_SPACE(STEP_SPACE)
    ) u_sel (
        .ctl (ctl),
        .inc (inc),
        .step(step)
    );

    fsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctl.run),
        .inc  (inc),
        .phase(phase_o)
    );

    fsk_slew_shaper #(
        .SMP_W(SMP_W), .LEVEL_LO(LEVEL_LO), .LEVEL_MID(LEVEL_MID),
        .LEVEL_HI(LEVEL_HI), .STEP_MAX(STEP_MAX)
    ) u_shp (
        .clk      (clk),
        .rst      (rst),
        .run      (ctl.run),
        .phase_msb(phase_o[ACC_W-1]),
        .step     (step),
        .sample   (sample_o)
    );

    AST_MARK_INC: assert property (@(posedge clk) disable iff (rst)
        (!rts_n && tx_bit) |=> (phase_o == ACC_W'($past(phase_o) + ACC_W'(INC_MARK)))); // R2

    AST_SPACE_INC: assert property (@(posedge clk) disable iff (rst)
        (!rts_n && !tx_bit) |=> (phase_o == ACC_W'($past(phase_o) + ACC_W'(INC_SPACE)))); // R3

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (phase_o == '0) && (sample_o == SMP_W'(LEVEL_MID))); // R1
endmodule

// File: tb/fsk_tone_gen_tb_top.sv
module fsk_tone_gen_tb_top;
    localparam int AW = 24;
    localparam int SW = 10;
    localparam logic [AW-1:0] INC_M = 24'd43691;
    localparam logic [AW-1:0] INC_S = 24'd80100;
    localparam logic [SW-1:0] LO  = 10'd256;
    localparam logic [SW-1:0] MID = 10'd512;
    localparam logic [SW-1:0] HI  = 10'd768;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rts_n = 1'b1;
    logic tx_bit = 1'b1;
    logic [AW-1:0] phase_o;
    logic [SW-1:0] sample_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [AW-1:0] ph;
        logic [SW-1:0] smp;
        string tp;
        string ts;
    } exp_t;
    exp_t q[$];

    logic [AW-1:0] m_acc = '0;
    logic [SW-1:0] m_smp = MID;
    logic last_b = 1'b1;

    always #4 clk = ~clk;

    fsk_tone_gen dut_i (
        .clk(clk), .rst(rst), .rts_n(rts_n), .tx_bit(tx_bit),
        .phase_o(phase_o), .sample_o(sample_o)
    );

    task automatic drive(input logic b, input logic rn, input logic r);
        exp_t e;
        logic [SW-1:0] tgt;
        logic [SW-1:0] st;
        logic [SW-1:0] prev;
        @(negedge clk);
        tx_bit = b; rts_n = rn; rst = r;
        prev = m_smp;
        if (r) begin
            m_acc = '0; m_smp = MID;
            e.tp = "R1"; e.ts = "R1";
        end else begin
            tgt = rn ? MID : (m_acc[AW-1] ? HI : LO);
            st  = (rn || b) ? 10'd4 : 10'd7;
            if (m_smp < tgt)      m_smp = ((tgt - m_smp) <= st) ? tgt : m_smp + st;
            else if (m_smp > tgt) m_smp = ((m_smp - tgt) <= st) ? tgt : m_smp - st;
            m_acc = rn ? '0 : m_acc + (b ? INC_M : INC_S);
            e.tp = rn ? "R5" : ((b != last_b) ? "R4" : (b ? "R2" : "R3"));
            e.ts = (prev == tgt) ? "R6" : (rn ? "R8" : "R7");
            last_b = b;
        end
        e.ph = m_acc; e.smp = m_smp;
        q.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(phase_o === e.ph, e.tp, int'(phase_o), int'(e.ph));
                check(sample_o === e.smp, e.ts, int'(sample_o), int'(e.smp));
                check(sample_o >= LO && sample_o <= HI, "R9", int'(sample_o), int'(MID));
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, 1'b1);
        // R1 explicit reset state
        @(negedge clk);
        check(phase_o == '0, "R1", int'(phase_o), 0);
        check(sample_o == MID, "R1", int'(sample_o), int'(MID));
        // idle: R5 hold
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b1, 1'b0);
        // continuous mark: R2, reaches plateaus R6
        for (int i = 0; i < 400; i++) drive(1'b1, 1'b0, 1'b0);
        // continuous space: R3
        for (int i = 0; i < 300; i++) drive(1'b0, 1'b0, 1'b0);
        // rapid tone changes mid-ramp: R4
        for (int i = 0; i < 400; i++) drive(((i / 20) % 2) == 0, 1'b0, 1'b0);
        // bit-rate pattern 384 clocks per bit
        for (int k = 0; k < 10; k++)
            for (int i = 0; i < 384; i++) drive(((k * 5 + 3) % 3) != 0 ? k[0] : 1'b1, 1'b0, 1'b0);
        // idle ramp back to mid: R8
        for (int i = 0; i < 200; i++) drive(1'b1, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        check(sample_o == MID, "R8", int'(sample_o), int'(MID));
        check(phase_o == '0, "R5", int'(phase_o), 0);
        // run again then reset mid-run: R1
        for (int i = 0; i < 150; i++) drive(1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 50; i++) drive(1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule